// File: doc/BRIEF.md
# Integer Multiply Unit with High/Low Pair Fusion

This execution unit multiplies two XLEN-bit integer operands for a RISC-style pipeline. It returns either the low XLEN bits of the product or the high XLEN bits of the full double-width product. For the high half, the operands can be treated as both signed, both unsigned, or signed first operand times unsigned second operand. All four operations share one signed multiplier that is (XLEN+1) bits wide. Each operand is given one extra bit, filled with its sign bit or with zero according to the mode.

A common code sequence asks for the high half and then the low half of the same product. The unit watches for this pair. A high-half operation qualifies when its destination register differs from both of its source registers. When it completes, the unit keeps the low half of that product. If the very next accepted operation is a low-half request naming the same two source registers in the same order, the unit answers it from the kept value. No second multiplication is done, and the result comes back one cycle earlier. Any other operation, a flush pulse or reset discards the kept value.

Operations enter on a valid/ready handshake and leave on a second valid/ready handshake. The unit holds one operation at a time. `in_ready` is high only while the unit is empty. Once `out_valid` rises, `out_data` and `out_fused` stay frozen until `out_ready` is seen high at a clock edge. The upstream side must keep its request stable while `in_ready` is low.

Top module: `imul_fuse_unit`

## Requirements
- R1: Opcode 0 (low half) returns bits [XLEN-1:0] of operand 1 times operand 2.
- R2: Opcode 1 returns bits [2·XLEN-1:XLEN] of the product with both operands signed.
- R3: Opcode 2 returns bits [2·XLEN-1:XLEN] of the product with both operands unsigned.
- R4: Opcode 3 returns bits [2·XLEN-1:XLEN] of signed operand 1 times unsigned operand 2.
- R5: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` stays low from acceptance until the result has been taken. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_fused` hold.
- R6: A result that is not fused has `out_fused` = 0 and shows on `out_valid` two cycles after the acceptance edge.
- R7: A fused result has `out_fused` = 1 and shows one cycle after acceptance. A low-half request is fused when the operation accepted just before it was a high-half operation with the same source 1 and source 2 specifiers, in that order, and a destination different from both.
- R8: A high-half operation whose destination equals source 1 or source 2 does not enable fusion of the following low-half request.
- R9: A low-half request is not fused if its sources are swapped, if another operation was accepted in between, or if the preceding low-half request already used the kept product.
- R10: A `flush` pulse, or reset, between the high-half and the low-half operation prevents fusion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discards the kept product |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 2 | 0 low, 1 high signed×signed, 2 high unsigned×unsigned, 3 high signed×unsigned |
| in_src1 | input | REG_IDX_W | Source 1 register specifier |
| in_src2 | input | REG_IDX_W | Source 2 register specifier |
| in_dst | input | REG_IDX_W | Destination register specifier |
| in_a | input | XLEN | Operand 1 |
| in_b | input | XLEN | Operand 2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | XLEN | Result |
| out_fused | output | 1 | Result came from the kept product |

## Verification
A result that needs the multiplier is due in the second cycle after the edge that accepts the request. A fused low-half result is due in the first cycle. The bench drives each request at a falling edge and starts counting cycles at the accepting rising edge. It then samples `out_valid` at each following falling edge, so the measured latency is compared against 2 or 1 exactly. Back-pressure runs hold `out_ready` low for several cycles after the result appears and sample at every falling edge in that window, checking that the data and the fused flag do not move.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    MOP_LO  = 2'd0,
    MOP_HSS = 2'd1,
    MOP_HUU = 2'd2,
    MOP_HSU = 2'd3
  } mop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_OUT  = 2'd2
  } mstate_e;

  function automatic logic mop_is_high(input logic [1:0] op);
    return op != MOP_LO;
  endfunction

endpackage

// File: rtl/imul_opnd_ext.sv
module imul_opnd_ext
  import imul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN:0]   ext_a,
  output logic [XLEN:0]   ext_b
);
  logic sgn_a;
  logic sgn_b;

  always_comb begin
    unique case (op)
      MOP_HSS: begin sgn_a = 1'b1; sgn_b = 1'b1; end
      MOP_HSU: begin sgn_a = 1'b1; sgn_b = 1'b0; end
      default: begin sgn_a = 1'b0; sgn_b = 1'b0; end
    endcase
  end

  assign ext_a = {sgn_a & a[XLEN-1], a};
  assign ext_b = {sgn_b & b[XLEN-1], b};
endmodule

// File: rtl/imul_prod.sv
module imul_prod #(
  parameter int XLEN = 32
) (
  input  logic [XLEN:0]   ext_a,
  input  logic [XLEN:0]   ext_b,
  input  logic            hi_sel,
  output logic [XLEN-1:0] result,
  output logic [XLEN-1:0] low_half
);
  localparam int PW = 2 * XLEN;

  logic signed [PW-1:0] wide_a;
  logic signed [PW-1:0] wide_b;
  logic signed [PW-1:0] prod;

  assign wide_a   = {{(XLEN-1){ext_a[XLEN]}}, ext_a};
  assign wide_b   = {{(XLEN-1){ext_b[XLEN]}}, ext_b};
  assign prod     = wide_a * wide_b;
  assign low_half = prod[XLEN-1:0];
  assign result   = hi_sel ? prod[PW-1:XLEN] : prod[XLEN-1:0];
endmodule

// File: rtl/imul_pair_track.sv
module imul_pair_track
  import imul_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 accept,
  input  logic [1:0]           op,
  input  logic [REG_IDX_W-1:0] src1,
  input  logic [REG_IDX_W-1:0] src2,
  input  logic [REG_IDX_W-1:0] dst,
  input  logic                 commit,
  input  logic [XLEN-1:0]      low_in,
  output logic                 hit,
  output logic [XLEN-1:0]      saved_low
);
  logic                 kept_vld;
  logic                 pend;
  logic [REG_IDX_W-1:0] kept_s1;
  logic [REG_IDX_W-1:0] kept_s2;
  logic                 qualifies;

  assign qualifies = mop_is_high(op) && (dst != src1) && (dst != src2);
  assign hit = kept_vld && (op == MOP_LO) && (src1 == kept_s1) && (src2 == kept_s2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kept_vld  <= 1'b0;
      pend      <= 1'b0;
      kept_s1   <= '0;
      kept_s2   <= '0;
      saved_low <= '0;
    end else if (flush) begin
      kept_vld <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (accept) begin
        kept_vld <= 1'b0;
        pend     <= !hit && qualifies;
        if (!hit && qualifies) begin
          kept_s1 <= src1;
          kept_s2 <= src2;
        end
      end
      if (commit && pend) begin
        kept_vld  <= 1'b1;
        pend      <= 1'b0;
        saved_low <= low_in;
      end
    end
  end
endmodule

// File: rtl/imul_fuse_unit.sv
module imul_fuse_unit
  import imul_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_op,
  input  logic [REG_IDX_W-1:0] in_src1,
  input  logic [REG_IDX_W-1:0] in_src2,
  input  logic [REG_IDX_W-1:0] in_dst,
  input  logic [XLEN-1:0]      in_a,
  input  logic [XLEN-1:0]      in_b,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      out_data,
  output logic                 out_fused
);
  mstate_e       state;
  logic          accept;
  logic          pair_hit;
  logic [XLEN-1:0] saved_low;
  logic [XLEN:0] ext_a;
  logic [XLEN:0] ext_b;
  logic [XLEN:0] ea_q;
  logic [XLEN:0] eb_q;
  logic          hi_q;
  logic [XLEN-1:0] mul_res;
  logic [XLEN-1:0] mul_low;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign accept    = in_valid && in_ready;

  imul_opnd_ext #(.XLEN(XLEN)) u_ext (
    .op(in_op), .a(in_a), .b(in_b), .ext_a(ext_a), .ext_b(ext_b)
  );

  imul_prod #(.XLEN(XLEN)) u_prod (
    .ext_a(ea_q), .ext_b(eb_q), .hi_sel(hi_q),
    .result(mul_res), .low_half(mul_low)
  );

  imul_pair_track #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .flush(flush), .accept(accept),
    .op(in_op), .src1(in_src1), .src2(in_src2), .dst(in_dst),
    .commit(state == ST_BUSY), .low_in(mul_low),
    .hit(pair_hit), .saved_low(saved_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ea_q      <= '0;
      eb_q      <= '0;
      hi_q      <= 1'b0;
      out_data  <= '0;
      out_fused <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (pair_hit) begin
            out_data  <= saved_low;
            out_fused <= 1'b1;
            state     <= ST_OUT;
          end else begin
            ea_q      <= ext_a;
            eb_q      <= ext_b;
            hi_q      <= mop_is_high(in_op);
            out_fused <= 1'b0;
            state     <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          out_data <= mul_res;
          state    <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imul_fuse_chk.sv
module imul_fuse_chk
  import imul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_op,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data,
  input logic            out_fused,
  input logic            pair_hit
);
  a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_fused));

  a_r5_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r6_plain_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && !out_fused |-> $past(in_valid && in_ready, 2) && !$past(in_valid && in_ready, 1));

  a_r7_fused_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && out_fused |-> $past(in_valid && in_ready) && $past(in_op) == MOP_LO);

  a_r10_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && in_valid && in_ready |-> !pair_hit);
endmodule

bind imul_fuse_unit imul_fuse_chk #(.XLEN(XLEN)) u_fuse_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .in_op(in_op), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_fused(out_fused),
  .pair_hit(pair_hit)
);

// File: tb/test_imul_fuse_unit.sv
`timescale 1ns/1ps
module test_imul_fuse_unit;
  localparam int XLEN = 32;
  localparam int RW   = 5;
  localparam int NV   = 10;

  localparam logic [XLEN-1:0] VEC_A [NV] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
    32'h8000_0000, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_0007, 32'hDEAD_BEEF};
  localparam logic [XLEN-1:0] VEC_B [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
    32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'h0001_FFFF, 32'hFFFF_FFF9, 32'h0000_0003};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'd0;
  logic [RW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [XLEN-1:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [XLEN-1:0] out_data;
  logic out_fused;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  imul_fuse_unit #(.XLEN(XLEN), .REG_IDX_W(RW)) i_imul_fuse_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_op(in_op), .in_src1(in_src1), .in_src2(in_src2),
    .in_dst(in_dst), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_fused(out_fused)
  );

  function automatic logic [XLEN-1:0] ref_mul(input logic [1:0] op,
                                               input logic [XLEN-1:0] a, b);
    logic [2*XLEN-1:0] sa, sb, za, zb, p;
    sa = {{XLEN{a[XLEN-1]}}, a};
    sb = {{XLEN{b[XLEN-1]}}, b};
    za = {{XLEN{1'b0}}, a};
    zb = {{XLEN{1'b0}}, b};
    case (op)
      2'd0: begin p = za * zb; return p[XLEN-1:0]; end
      2'd1: p = sa * sb;
      2'd2: p = za * zb;
      default: p = sa * zb;
    endcase
    return p[2*XLEN-1:XLEN];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [RW-1:0] s1, s2, d,
                        input logic [XLEN-1:0] a, b, input bit exp_f,
                        input int hold, input string req);
    logic [XLEN-1:0] exp_d;
    logic [XLEN-1:0] got;
    int lat;
    exp_d = ref_mul(op, a, b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    out_ready = (hold == 0);
    in_op = op; in_src1 = s1; in_src2 = s2; in_dst = d; in_a = a; in_b = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    got = out_data;
    check(got == exp_d, req, "data", 64'(got), 64'(exp_d));
    check(out_fused == exp_f, exp_f ? "R7" : "R6", "fused flag",
          64'(out_fused), 64'(exp_f));
    check(lat == (exp_f ? 1 : 2), exp_f ? "R7" : "R6", "latency",
          64'(lat), 64'(exp_f ? 1 : 2));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(out_valid && out_data == got, "R5", "held result",
            64'({out_valid, out_data}), 64'({1'b1, got}));
    end
    out_ready = 1'b1;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R5", "reset state",
          64'({out_valid, in_ready}), 64'b01);

    // table walk: dst equals src1, so nothing fuses; R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      run_op(2'd1, 5'd1, 5'd2, 5'd1, VEC_A[v], VEC_B[v], 1'b0, 0, "R2");
      run_op(2'd2, 5'd1, 5'd2, 5'd1, VEC_A[v], VEC_B[v], 1'b0, 0, "R3");
      run_op(2'd3, 5'd1, 5'd2, 5'd1, VEC_A[v], VEC_B[v], 1'b0, 0, "R4");
      run_op(2'd0, 5'd1, 5'd2, 5'd1, VEC_A[v], VEC_B[v], 1'b0, 0, "R1");
    end

    // R7: qualifying pairs for each high mode
    run_op(2'd1, 5'd3, 5'd4, 5'd5, 32'hFFFF_FFF9, 32'd12345, 1'b0, 0, "R2");
    run_op(2'd0, 5'd3, 5'd4, 5'd9, 32'hFFFF_FFF9, 32'd12345, 1'b1, 0, "R7");
    run_op(2'd2, 5'd6, 5'd7, 5'd8, 32'h8000_0000, 32'h8000_0000, 1'b0, 0, "R3");
    run_op(2'd0, 5'd6, 5'd7, 5'd6, 32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R7");
    run_op(2'd3, 5'd10, 5'd11, 5'd12, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 0, "R4");
    run_op(2'd0, 5'd10, 5'd11, 5'd1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1, 2, "R7");
    // R9: kept product is used once only
    run_op(2'd0, 5'd10, 5'd11, 5'd1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 0, "R9");

    // R8: destination overlaps a source
    run_op(2'd1, 5'd3, 5'd4, 5'd4, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 0, "R8");
    run_op(2'd0, 5'd3, 5'd4, 5'd9, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 0, "R8");
    run_op(2'd2, 5'd3, 5'd4, 5'd3, 32'h0000_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R8");
    run_op(2'd0, 5'd3, 5'd4, 5'd9, 32'h0000_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R8");

    // R9: swapped sources
    run_op(2'd1, 5'd3, 5'd4, 5'd5, 32'h0000_0011, 32'h0000_0011, 1'b0, 0, "R9");
    run_op(2'd0, 5'd4, 5'd3, 5'd9, 32'h0000_0011, 32'h0000_0011, 1'b0, 0, "R9");
    // R9: another operation in between
    run_op(2'd1, 5'd3, 5'd4, 5'd5, 32'h0000_1234, 32'hFFFF_0001, 1'b0, 0, "R9");
    run_op(2'd0, 5'd20, 5'd21, 5'd22, 32'd5, 32'd6, 1'b0, 0, "R1");
    run_op(2'd0, 5'd3, 5'd4, 5'd9, 32'h0000_1234, 32'hFFFF_0001, 1'b0, 0, "R9");

    // R10: flush between the pair
    run_op(2'd3, 5'd3, 5'd4, 5'd5, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 0, "R4");
    pulse_flush();
    run_op(2'd0, 5'd3, 5'd4, 5'd9, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 0, "R10");
    // R10: reset between the pair
    run_op(2'd1, 5'd3, 5'd4, 5'd5, 32'h0000_0100, 32'h0000_0200, 1'b0, 0, "R2");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_op(2'd0, 5'd3, 5'd4, 5'd9, 32'h0000_0100, 32'h0000_0200, 1'b0, 0, "R10");

    // R5: back-pressure on a plain result
    run_op(2'd2, 5'd1, 5'd2, 5'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3, "R3");
    @(negedge clk);
    check(!out_valid && in_ready, "R5", "released after take",
          64'({out_valid, in_ready}), 64'b01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule